// File: doc/BRIEF.md
# Control Packet to Register Bridge

The bridge accepts 32-bit command packets on an AXI4-Stream slave port. Each packet holds two header words, an optional 64-bit timestamp (two words), one operation word and between one and fifteen payload words. The whole packet is buffered. The operation word is decoded and becomes one single-cycle write, read or write-then-read strobe on a simple register port. The bridge then waits for that port's acknowledge.

After the acknowledge, the buffered packet is replayed on an AXI4-Stream master port as the response. The acknowledge flag in header word 0 is set. The status goes into the top two bits of the operation word, and the first payload word is replaced by the result. A sleep command and any unknown opcode are answered locally, without touching the register port. A packet that carries no payload word is swallowed and gets no response. The command side and the response side run on the same clock.

Top module: `cmdpkt_reg_bridge`

## Requirements
- R1: While reset is held and in the first cycle after it, `cmd_tready` is 1, `rsp_tvalid` is 0 and neither `rp_wr` nor `rp_rd` is asserted.
- R2: Response word 0 equals request word 0 with bit 31 (acknowledge) forced to 1. Header word 1, the timestamp words and every payload word after the first are copied unchanged, and `rsp_tlast` marks the last word.
- R3: Bit 30 of word 0 is the has-time flag. The operation word is at index 4 when the flag is 1 and at index 2 when it is 0. In the response its bits 31:30 hold the status and bits 29:0 are copied. Status codes: 0 OK, 1 command error, 2 timestamp error, 3 warning.
- R4: Operation-word fields are address [19:0], byte enable [23:20] and opcode [27:24]. The register port receives this address and byte enable, the first payload word as write data, and the has-time flag. The time value is {word 3, word 2} when the flag is set and 0 when it is clear.
- R5: Opcode 1 (write) pulses `rp_wr` alone for one cycle. The response carries the port's status and echoes the first payload word.
- R6: Opcode 2 (read) pulses `rp_rd` alone, and opcode 3 (write-then-read) pulses both in the same single cycle. The response carries the port's status and the port's read data as the first payload word. The acknowledge must come at least one cycle after the strobe.
- R7: Opcodes 4 to 15 produce no strobe. The response carries status 1 and echoes the first payload word.
- R8: Opcode 0 (sleep) produces no strobe. The bridge waits N cycles, where N is the first payload word, and then responds with status 0 and the word echoed. The first response word becomes valid N+2 cycles after the last request word is accepted.
- R9: A packet that ends at or before its operation word is consumed without a strobe and without a response. The next packet is handled normally.
- R10: While a response word is offered and not taken, `rsp_tdata` and `rsp_tlast` stay stable. `cmd_tready` is 0 from the last request beat until the last response beat has been accepted.
- R11: Packets with up to 15 payload words, with and without a timestamp, are returned in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst | input | 1 | Synchronous active-high reset |
| cmd_tdata | input | 32 | Request packet word |
| cmd_tlast | input | 1 | Last word of a request packet |
| cmd_tvalid | input | 1 | Request word valid |
| cmd_tready | output | 1 | Bridge can take a request word |
| rsp_tdata | output | 32 | Response packet word |
| rsp_tlast | output | 1 | Last word of a response packet |
| rsp_tvalid | output | 1 | Response word valid |
| rsp_tready | input | 1 | Downstream takes the response word |
| rp_wr | output | 1 | Single-cycle write strobe |
| rp_rd | output | 1 | Single-cycle read strobe |
| rp_addr | output | 20 | Register address |
| rp_wdata | output | 32 | Write data (first payload word) |
| rp_ben | output | 4 | Byte enables |
| rp_has_time | output | 1 | Request carried a timestamp |
| rp_time | output | 64 | Timestamp, or 0 when absent |
| rp_ack | input | 1 | Register port acknowledge |
| rp_status | input | 2 | Register port status |
| rp_rdata | input | 32 | Register port read data |

## Verification
A vector table sweeps every opcode class with and without a timestamp, with payload lengths of one, several and fifteen words. The register model derives its status from address bits and its read data from the address. This shows whether the first payload word was echoed or replaced and whether the operation word was found at the right index. Response back-pressure patterns from none to heavy show whether words are held or lost. Directed cases cover sleep latency for zero and non-zero counts, packets without payload that must vanish, and the strobe counts and register-port fields seen for each opcode.

// File: rtl/cmdpkt_pkg.sv
package cmdpkt_pkg;

    localparam int WORD_W    = 32;
    localparam int ADDR_W    = 20;
    localparam int BEN_W     = 4;
    localparam int STS_W     = 2;
    localparam int HDR_WORDS = 2;
    localparam int TS_WORDS  = 2;
    localparam int ACK_BIT   = 31;
    localparam int HT_BIT    = 30;

    localparam logic [3:0] OPC_SLEEP = 4'd0;
    localparam logic [3:0] OPC_WRITE = 4'd1;
    localparam logic [3:0] OPC_READ  = 4'd2;
    localparam logic [3:0] OPC_WRRD  = 4'd3;

    localparam logic [STS_W-1:0] STS_OK     = 2'd0;
    localparam logic [STS_W-1:0] STS_CMDERR = 2'd1;

    typedef struct packed {
        logic [STS_W-1:0]  status;
        logic [1:0]        spare;
        logic [3:0]        opcode;
        logic [BEN_W-1:0]  ben;
        logic [ADDR_W-1:0] addr;
    } op_word_t;

    typedef enum logic [2:0] {
        S_RECV,
        S_ISSUE,
        S_WAIT,
        S_SLEEP,
        S_SEND
    } bridge_state_e;

    // word index of the operation word for a given has-time flag
    function automatic int unsigned op_index(input logic has_time);
        return has_time ? (HDR_WORDS + TS_WORDS) : HDR_WORDS;
    endfunction

endpackage

// File: rtl/cmdpkt_word_store.sv
module cmdpkt_word_store
    import cmdpkt_pkg::*;
#(
    parameter int DEPTH = 20,
    localparam int IW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IW-1:0]     wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              has_time,
    input  logic [IW-1:0]     rd_idx,
    output logic [WORD_W-1:0] rd_word,
    output op_word_t          op_word,
    output logic [WORD_W-1:0] data0,
    output logic [63:0]       stamp
);
    logic [WORD_W-1:0] mem [DEPTH];
    logic [IW-1:0]     op_i;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    always_comb begin
        op_i    = IW'(op_index(has_time));
        rd_word = mem[rd_idx];
        op_word = op_word_t'(mem[op_i]);
        data0   = mem[op_i + IW'(1)];
        stamp   = has_time ? {mem[HDR_WORDS + 1], mem[HDR_WORDS]} : 64'd0;
    end
endmodule

// File: rtl/cmdpkt_sleep_timer.sv
module cmdpkt_sleep_timer #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)        remain <= '0;
        else if (load)  remain <= load_val;
        else if (!done) remain <= remain - 1'b1;
    end

    assign done = (remain == '0);

    // R8
    sleep_count_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !done) |=> (remain < $past(remain)));
endmodule

// File: rtl/cmdpkt_reg_bridge.sv
module cmdpkt_reg_bridge
    import cmdpkt_pkg::*;
#(
    parameter int MAX_DATA = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] cmd_tdata,
    input  logic              cmd_tlast,
    input  logic              cmd_tvalid,
    output logic              cmd_tready,
    output logic [WORD_W-1:0] rsp_tdata,
    output logic              rsp_tlast,
    output logic              rsp_tvalid,
    input  logic              rsp_tready,
    output logic              rp_wr,
    output logic              rp_rd,
    output logic [ADDR_W-1:0] rp_addr,
    output logic [WORD_W-1:0] rp_wdata,
    output logic [BEN_W-1:0]  rp_ben,
    output logic              rp_has_time,
    output logic [63:0]       rp_time,
    input  logic              rp_ack,
    input  logic [STS_W-1:0]  rp_status,
    input  logic [WORD_W-1:0] rp_rdata
);
    localparam int DEPTH = HDR_WORDS + TS_WORDS + 1 + MAX_DATA;
    localparam int IW    = $clog2(DEPTH + 1);

    bridge_state_e     state;
    logic [IW-1:0]     wcnt, rcnt, nwords;
    logic              ht_q;
    logic [STS_W-1:0]  sts_q;
    logic [WORD_W-1:0] rsp_q;

    logic              cmd_beat, rsp_beat, ht_now, tmr_done;
    logic [IW-1:0]     opi_now, opi_q, words_now;
    logic [WORD_W-1:0] st_word, data0;
    op_word_t          op;

    cmdpkt_word_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .wr_en    (cmd_beat && (wcnt != IW'(DEPTH))),
        .wr_idx   (wcnt),
        .wr_data  (cmd_tdata),
        .has_time (ht_q),
        .rd_idx   (rcnt),
        .rd_word  (st_word),
        .op_word  (op),
        .data0    (data0),
        .stamp    (rp_time)
    );

    cmdpkt_sleep_timer #(.CW(WORD_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (state == S_ISSUE && op.opcode == OPC_SLEEP),
        .load_val (data0),
        .done     (tmr_done)
    );

    always_comb begin
        cmd_tready = (state == S_RECV);
        cmd_beat   = cmd_tvalid && cmd_tready;
        rsp_tvalid = (state == S_SEND);
        rsp_beat   = rsp_tvalid && rsp_tready;
        ht_now     = (wcnt == '0) ? cmd_tdata[HT_BIT] : ht_q;
        opi_now    = IW'(op_index(ht_now));
        opi_q      = IW'(op_index(ht_q));
        words_now  = (wcnt == IW'(DEPTH)) ? wcnt : wcnt + IW'(1);
        rsp_tlast  = (rcnt == nwords - IW'(1));
        if (rcnt == '0)                rsp_tdata = {1'b1, st_word[ACK_BIT-1:0]};
        else if (rcnt == opi_q)        rsp_tdata = {sts_q, st_word[WORD_W-STS_W-1:0]};
        else if (rcnt == opi_q + IW'(1)) rsp_tdata = rsp_q;
        else                           rsp_tdata = st_word;
        rp_wr       = (state == S_ISSUE) && (op.opcode == OPC_WRITE || op.opcode == OPC_WRRD);
        rp_rd       = (state == S_ISSUE) && (op.opcode == OPC_READ  || op.opcode == OPC_WRRD);
        rp_addr     = op.addr;
        rp_ben      = op.ben;
        rp_wdata    = data0;
        rp_has_time = ht_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_RECV;
            wcnt   <= '0;
            rcnt   <= '0;
            nwords <= '0;
            ht_q   <= 1'b0;
            sts_q  <= STS_OK;
            rsp_q  <= '0;
        end else begin
            unique case (state)
                S_RECV: if (cmd_beat) begin
                    if (wcnt == '0) ht_q <= cmd_tdata[HT_BIT];
                    if (wcnt != IW'(DEPTH)) wcnt <= wcnt + IW'(1);
                    if (cmd_tlast) begin
                        wcnt   <= '0;
                        nwords <= words_now;
                        if (words_now > opi_now + IW'(1)) state <= S_ISSUE;
                    end
                end
                S_ISSUE: begin
                    if (op.opcode == OPC_SLEEP) begin
                        state <= S_SLEEP;
                    end else if (op.opcode == OPC_WRITE || op.opcode == OPC_READ ||
                                 op.opcode == OPC_WRRD) begin
                        state <= S_WAIT;
                    end else begin
                        sts_q <= STS_CMDERR;
                        rsp_q <= data0;
                        state <= S_SEND;
                    end
                end
                S_WAIT: if (rp_ack) begin
                    sts_q <= rp_status;
                    rsp_q <= (op.opcode == OPC_WRITE) ? data0 : rp_rdata;
                    state <= S_SEND;
                end
                S_SLEEP: if (tmr_done) begin
                    sts_q <= STS_OK;
                    rsp_q <= data0;
                    state <= S_SEND;
                end
                S_SEND: if (rsp_beat) begin
                    if (rsp_tlast) begin
                        rcnt  <= '0;
                        state <= S_RECV;
                    end else begin
                        rcnt <= rcnt + IW'(1);
                    end
                end
                default: state <= S_RECV;
            endcase
        end
    end

    // R5
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        (rp_wr || rp_rd) |=> !(rp_wr || rp_rd));
    // R10
    rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_tvalid && !rsp_tready) |=> (rsp_tvalid && $stable(rsp_tdata) && $stable(rsp_tlast)));
    // R10
    io_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(cmd_tready && rsp_tvalid));
    // R6
    no_early_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        (rp_wr || rp_rd) |=> !rsp_tvalid);
    // R9
    rsp_needs_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rsp_tvalid) |-> !$past(cmd_tready));
endmodule

// File: tb/tb_cmdpkt_reg_bridge.sv
module tb_cmdpkt_reg_bridge;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] cmd_tdata;
    logic        cmd_tlast, cmd_tvalid, cmd_tready;
    logic [31:0] rsp_tdata;
    logic        rsp_tlast, rsp_tvalid, rsp_tready;
    logic        rp_wr, rp_rd, rp_has_time;
    logic [19:0] rp_addr;
    logic [31:0] rp_wdata;
    logic [3:0]  rp_ben;
    logic [63:0] rp_time;
    logic        rp_ack;
    logic [1:0]  rp_status;
    logic [31:0] rp_rdata;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmdpkt_reg_bridge dut (
        .clk(clk), .rst(rst),
        .cmd_tdata(cmd_tdata), .cmd_tlast(cmd_tlast), .cmd_tvalid(cmd_tvalid), .cmd_tready(cmd_tready),
        .rsp_tdata(rsp_tdata), .rsp_tlast(rsp_tlast), .rsp_tvalid(rsp_tvalid), .rsp_tready(rsp_tready),
        .rp_wr(rp_wr), .rp_rd(rp_rd), .rp_addr(rp_addr), .rp_wdata(rp_wdata), .rp_ben(rp_ben),
        .rp_has_time(rp_has_time), .rp_time(rp_time),
        .rp_ack(rp_ack), .rp_status(rp_status), .rp_rdata(rp_rdata)
    );

    // register port model: answer one cycle after a strobe
    int          n_wr = 0, n_rd = 0, n_both = 0;
    logic [19:0] cap_addr;
    logic [31:0] cap_wdata;
    logic [3:0]  cap_ben;
    logic        cap_ht;
    logic [63:0] cap_time;
    always_ff @(posedge clk) begin
        if (rst) begin
            rp_ack <= 1'b0; rp_status <= 2'd0; rp_rdata <= '0;
        end else begin
            rp_ack    <= rp_wr | rp_rd;
            rp_status <= rp_addr[19:18];
            rp_rdata  <= {12'hA5C, rp_addr};
            if (rp_wr | rp_rd) begin
                cap_addr <= rp_addr; cap_wdata <= rp_wdata; cap_ben <= rp_ben;
                cap_ht <= rp_has_time; cap_time <= rp_time;
            end
            if (rp_wr && !rp_rd) n_wr++;
            if (rp_rd && !rp_wr) n_rd++;
            if (rp_rd && rp_wr)  n_both++;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    logic [31:0] pkt [20];
    logic [31:0] exp_w [20];
    int          pkt_n;

    task automatic send_pkt();
        for (int i = 0; i < pkt_n; i++) begin
            cmd_tvalid = 1'b1; cmd_tdata = pkt[i]; cmd_tlast = (i == pkt_n - 1);
            forever begin
                automatic bit ok = cmd_tready;
                @(negedge clk);
                if (ok) break;
            end
        end
        cmd_tvalid = 1'b0; cmd_tlast = 1'b0;
    endtask

    // build and run one packet, check the response word by word
    task automatic run_case(input logic [3:0] opc, input logic ht, input int nd,
                            input logic [19:0] addr, input logic [3:0] stall, input string req);
        int opi, got, cyc, wr0, rd0, bo0;
        logic [31:0] d0;
        opi = ht ? 4 : 2;
        pkt_n = opi + 1 + nd;
        pkt[0] = {1'b0, ht, 10'h2AB, addr[19:0]};
        pkt[1] = 32'hBEEF_0000 | 32'(nd);
        if (ht) begin pkt[2] = 32'h7654_3210 ^ 32'(addr); pkt[3] = 32'h0123_4567; end
        pkt[opi] = {2'b00, 2'b00, opc, 4'h9 ^ addr[3:0], addr};
        for (int i = 0; i < nd; i++) pkt[opi + 1 + i] = {8'(i + 1), 4'h0, addr};
        if (opc == 4'd0) pkt[opi + 1] = 32'(addr[3:0]);
        d0 = pkt[opi + 1];
        for (int i = 0; i < pkt_n; i++) exp_w[i] = pkt[i];
        exp_w[0][31] = 1'b1;
        case (opc)
            4'd0: exp_w[opi][31:30] = 2'd0;
            4'd1: exp_w[opi][31:30] = addr[19:18];
            4'd2, 4'd3: begin exp_w[opi][31:30] = addr[19:18]; exp_w[opi + 1] = {12'hA5C, addr}; end
            default: exp_w[opi][31:30] = 2'd1;
        endcase
        wr0 = n_wr; rd0 = n_rd; bo0 = n_both;
        send_pkt();
        got = 0; cyc = 0;
        while (!rsp_tvalid) begin @(negedge clk); cyc++; end
        if (opc == 4'd0) chk(cyc == int'(d0) + 2, "R8 sleep latency", 64'(cyc), 64'(d0 + 2));
        for (int c = 0; got < pkt_n && c < 400; c++) begin
            automatic bit v, r;
            rsp_tready = !stall[c % 4];
            v = rsp_tvalid; r = rsp_tready;
            if (v && r) begin
                chk(rsp_tdata == exp_w[got], $sformatf("%s word %0d (R2/R3)", req, got), 64'(rsp_tdata), 64'(exp_w[got]));
                chk(rsp_tlast == (got == pkt_n - 1), "R2 tlast", 64'(rsp_tlast), 64'(got == pkt_n - 1));
                got++;
            end
            @(negedge clk);
        end
        rsp_tready = 1'b0;
        chk(got == pkt_n, "R11 response length", 64'(got), 64'(pkt_n));
        chk(n_wr - wr0 == (opc == 4'd1 ? 1 : 0), "R5 write strobes", 64'(n_wr - wr0), 64'(opc == 4'd1));
        chk(n_rd - rd0 == (opc == 4'd2 ? 1 : 0), "R6 read strobes", 64'(n_rd - rd0), 64'(opc == 4'd2));
        chk(n_both - bo0 == (opc == 4'd3 ? 1 : 0), "R6 combined strobes", 64'(n_both - bo0), 64'(opc == 4'd3));
        if (opc >= 4'd1 && opc <= 4'd3) begin
            chk(cap_addr == addr && cap_ben == (4'h9 ^ addr[3:0]), "R4 addr/ben", {cap_ben, cap_addr}, {4'h9 ^ addr[3:0], addr});
            chk(cap_wdata == d0, "R4 wdata", 64'(cap_wdata), 64'(d0));
            chk(cap_ht == ht && cap_time == (ht ? {pkt[3], pkt[2]} : 64'd0), "R4 time", cap_time,
                ht ? {pkt[3], pkt[2]} : 64'd0);
        end
    endtask

    // {opcode, has_time, ndata, addr, stall mask}
    localparam logic [32:0] VECS [10] = '{
        {4'd1, 1'b0, 4'd1,  20'h4_0123, 4'b0000},
        {4'd1, 1'b1, 4'd3,  20'hC_5A5A, 4'b0101},
        {4'd2, 1'b0, 4'd2,  20'h8_00FF, 4'b0011},
        {4'd2, 1'b1, 4'd15, 20'h0_1234, 4'b1110},
        {4'd3, 1'b0, 4'd15, 20'h4_BEEF, 4'b0000},
        {4'd3, 1'b1, 4'd1,  20'hF_F00D, 4'b1000},
        {4'd7, 1'b0, 4'd2,  20'h8_7777, 4'b0000},
        {4'd15,1'b1, 4'd4,  20'hC_0F0F, 4'b0110},
        {4'd0, 1'b0, 4'd2,  20'h0_0005, 4'b0000},
        {4'd0, 1'b1, 4'd1,  20'h4_00A0, 4'b0010}
    };

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; cmd_tvalid = 1'b0; cmd_tlast = 1'b0; cmd_tdata = '0; rsp_tready = 1'b0;
        repeat (3) @(negedge clk);
        // R1 during reset
        chk(cmd_tready && !rsp_tvalid && !rp_wr && !rp_rd, "R1 reset state",
            {cmd_tready, rsp_tvalid, rp_wr, rp_rd}, 4'b1000);
        rst = 1'b0;
        @(negedge clk);
        chk(cmd_tready && !rsp_tvalid && !rp_wr && !rp_rd, "R1 after reset",
            {cmd_tready, rsp_tvalid, rp_wr, rp_rd}, 4'b1000);

        for (int v = 0; v < 10; v++)
            run_case(VECS[v][32:29], VECS[v][28], int'(VECS[v][27:24]), VECS[v][23:4], VECS[v][3:0],
                     $sformatf("vector %0d", v));

        // R7 unknown opcode with heavy stall
        run_case(4'd4, 1'b0, 1, 20'h0_0001, 4'b0111, "R7 opcode 4");
        // R8 zero-length sleep
        run_case(4'd0, 1'b0, 1, 20'h0_0000, 4'b0000, "R8 sleep 0");

        // R9 packets without payload, with and without timestamp
        for (int h = 0; h < 2; h++) begin
            automatic int w0 = n_wr + n_rd + n_both;
            automatic bit seen = 1'b0;
            pkt_n = (h == 1) ? 5 : 3;
            pkt[0] = {1'b0, h[0], 30'h1};
            for (int i = 1; i < pkt_n - 1; i++) pkt[i] = 32'h5;
            pkt[pkt_n - 1] = {8'h01, 4'h0, 20'h4_0001};
            send_pkt();
            rsp_tready = 1'b1;
            for (int c = 0; c < 12; c++) begin
                if (rsp_tvalid) seen = 1'b1;
                @(negedge clk);
            end
            rsp_tready = 1'b0;
            chk(!seen, "R9 no response", 64'(seen), 64'd0);
            chk(cmd_tready, "R9 ready again", 64'(cmd_tready), 64'd1);
            chk(n_wr + n_rd + n_both == w0, "R9 no strobe", 64'(n_wr + n_rd + n_both), 64'(w0));
            run_case(4'd2, h[0], 2, 20'h8_4321, 4'b0000, "R9 follow-up");
        end

        // R10 input blocked while response pending
        pkt_n = 4;
        pkt[0] = 32'h0; pkt[1] = 32'h1; pkt[2] = {4'h0, 4'd1, 4'hF, 20'h0_0042}; pkt[3] = 32'h99;
        send_pkt();
        repeat (4) @(negedge clk);
        chk(rsp_tvalid && !cmd_tready, "R10 back-pressure holds", {rsp_tvalid, cmd_tready}, 2'b10);
        rsp_tready = 1'b1;
        while (!(rsp_tvalid && rsp_tlast)) @(negedge clk);
        @(negedge clk);
        rsp_tready = 1'b0;
        chk(cmd_tready, "R10 ready after response", 64'(cmd_tready), 64'd1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule